// File: doc/BRIEF.md
# Sequential Offset Register File

This block stores the two threshold offsets used by a FIFO's almost-empty and almost-full warning logic. There is no address bus. Configuration software selects offset access with a single select line. It then uses the FIFO's ordinary write strobe and data input to load the registers, and the read strobes and data output to read them back. The register file steps through a fixed four-slot cycle on its own. Separate write and read positions let a partial load or partial read-back resume where it stopped.

Each offset is spread over two 9-bit slots: a low slot and a high slot. How many bits the high slot carries depends on the FIFO depth parameter:

| Depth | Offset width | High-slot bits |
|-------|--------------|----------------|
| 512, 1K | 9 bits | none |
| 2K | 10 bits | 1 |
| 4K | 11 bits | 2 |

The two assembled offsets are driven continuously to the flag comparators. The FIFO storage and the comparators themselves sit outside this block.

Top module: `ofs_regfile`

## Requirements
- R1: A synchronous active-high `rst` sets both assembled offsets to 7 and `rd_data` to 0. It also puts both the write position and the read position at the first slot.
- R2: Writes fill slots in this fixed order: 0 = almost-empty low, 1 = almost-empty high, 2 = almost-full low, 3 = almost-full high. After slot 3, the next write goes back to slot 0.
- R3: A slot is written on the rising clock edge when `cfg_sel` and `wr_en` are both high. With any gap of idle cycles, the next write lands on the slot after the last one written.
- R4: A read-back happens when `cfg_sel`, `rd_en_a` and `rd_en_b` are all high and no write is taken. The current read slot then appears on `rd_data` after that edge. The read position follows the same order and wrap as writes, independently of the write position.
- R5: When no read-back is taken, `rd_data` and the read position keep their values. This includes the case where only one of the two read enables is high.
- R6: When a write and a read-back are requested in the same cycle, the write is taken. The read is ignored: `rd_data` and the read position do not change.
- R7: A low slot holds offset bits 8:0. A high slot holds offset bits 9 and up in its lowest positions: bit 9 at depth 2K, bits 10:9 at depth 4K. All other high-slot bits are ignored when written and read back as zero.
- R8: With `cfg_sel` low, `wr_en` and the read enables change neither offset, nor `rd_data`, nor either position.
- R9: `ae_offset` and `af_offset` show a written value from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_sel | input | 1 | Routes the write/read strobes to the offset registers |
| wr_en | input | 1 | Write strobe |
| rd_en_a | input | 1 | First read strobe |
| rd_en_b | input | 1 | Second read strobe |
| wr_data | input | 9 | Data input word |
| rd_data | output | 9 | Registered read-back word |
| ae_offset | output | OFS_W | Assembled almost-empty offset |
| af_offset | output | OFS_W | Assembled almost-full offset |

## Verification
The bench goes after the following corner cases, and what a faulty design would do in each:

- **Wrap after the fourth slot.** A design that gets this wrong would overwrite a slot beyond the almost-full high register, or stall there.
- **Write resuming after idle cycles.** A position that resets or advances on idle cycles would load the wrong offset half.
- **Read and write requested in the same cycle.** A design that serves the read would move the read position and corrupt the read-back sequence.
- **High slot with ones in its unused bits.** A design that stores or echoes those bits would return nonzero upper bits, or widen the threshold.

Random traffic on both positions checks that they advance independently of each other.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

    localparam int WORD_W = 9;
    localparam int RESET_OFS = 7;

    typedef enum logic [1:0] {
        SLOT_AE_LO = 2'd0,
        SLOT_AE_HI = 2'd1,
        SLOT_AF_LO = 2'd2,
        SLOT_AF_HI = 2'd3
    } slot_e;

    typedef struct packed {
        logic wr_take;
        logic rd_take;
    } access_t;

    function automatic int ofs_width(input int depth);
        int w;
        w = $clog2(depth) - 1;
        return (w < WORD_W) ? WORD_W : w;
    endfunction

    function automatic slot_e slot_next(input slot_e s);
        return slot_e'(s + 2'd1);
    endfunction

    function automatic logic slot_is_af(input slot_e s);
        return s[1];
    endfunction

    function automatic logic slot_is_hi(input slot_e s);
        return s[0];
    endfunction

endpackage

// File: rtl/ofs_arbiter.sv
module ofs_arbiter
    import ofs_pkg::*;
(
    input  logic    cfg_sel,
    input  logic    wr_en,
    input  logic    rd_en_a,
    input  logic    rd_en_b,
    output access_t acc
);
    logic wr_req;
    logic rd_req;

    always_comb begin
        wr_req      = cfg_sel & wr_en;
        rd_req      = cfg_sel & rd_en_a & rd_en_b;
        acc.wr_take = wr_req;
        acc.rd_take = rd_req & ~wr_req;
    end
endmodule

// File: rtl/ofs_seq.sv
module ofs_seq
    import ofs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    output slot_e slot
);
    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= SLOT_AE_LO;
        end else if (step) begin
            slot <= slot_next(slot);
        end
    end
endmodule

// File: rtl/ofs_store.sv
module ofs_store
    import ofs_pkg::*;
#(
    parameter int OFS_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_take,
    input  slot_e             wr_slot,
    input  logic [WORD_W-1:0] wr_data,
    output logic [OFS_W-1:0]  ae_ofs,
    output logic [OFS_W-1:0]  af_ofs
);
    localparam int HI_W = OFS_W - WORD_W;
    localparam logic [WORD_W-1:0] LO_RESET = WORD_W'(RESET_OFS);

    logic [WORD_W-1:0] ae_lo;
    logic [WORD_W-1:0] af_lo;
    logic              lo_hit;

    assign lo_hit = wr_take & ~slot_is_hi(wr_slot);

    always_ff @(posedge clk) begin
        if (rst) begin
            ae_lo <= LO_RESET;
            af_lo <= LO_RESET;
        end else if (lo_hit) begin
            if (slot_is_af(wr_slot)) begin
                af_lo <= wr_data;
            end else begin
                ae_lo <= wr_data;
            end
        end
    end

    generate
        if (HI_W > 0) begin : g_hi
            logic [HI_W-1:0] ae_hi;
            logic [HI_W-1:0] af_hi;
            logic            hi_hit;

            assign hi_hit = wr_take & slot_is_hi(wr_slot);

            always_ff @(posedge clk) begin
                if (rst) begin
                    ae_hi <= '0;
                    af_hi <= '0;
                end else if (hi_hit) begin
                    if (slot_is_af(wr_slot)) begin
                        af_hi <= wr_data[HI_W-1:0];
                    end else begin
                        ae_hi <= wr_data[HI_W-1:0];
                    end
                end
            end

            assign ae_ofs = {ae_hi, ae_lo};
            assign af_ofs = {af_hi, af_lo};
        end else begin : g_nohi
            assign ae_ofs = ae_lo;
            assign af_ofs = af_lo;
        end
    endgenerate
endmodule

// File: rtl/ofs_readback.sv
module ofs_readback
    import ofs_pkg::*;
#(
    parameter int OFS_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_take,
    input  slot_e             rd_slot,
    input  logic [OFS_W-1:0]  ae_ofs,
    input  logic [OFS_W-1:0]  af_ofs,
    output logic [WORD_W-1:0] rd_data
);
    localparam int HI_W = OFS_W - WORD_W;

    logic [WORD_W-1:0] ae_hi_view;
    logic [WORD_W-1:0] af_hi_view;
    logic [WORD_W-1:0] sel_word;

    generate
        if (HI_W > 0) begin : g_hi_view
            always_comb begin
                ae_hi_view = '0;
                af_hi_view = '0;
                ae_hi_view[HI_W-1:0] = ae_ofs[OFS_W-1:WORD_W];
                af_hi_view[HI_W-1:0] = af_ofs[OFS_W-1:WORD_W];
            end
        end else begin : g_zero_view
            assign ae_hi_view = '0;
            assign af_hi_view = '0;
        end
    endgenerate

    always_comb begin
        unique case (rd_slot)
            SLOT_AE_LO: sel_word = ae_ofs[WORD_W-1:0];
            SLOT_AE_HI: sel_word = ae_hi_view;
            SLOT_AF_LO: sel_word = af_ofs[WORD_W-1:0];
            SLOT_AF_HI: sel_word = af_hi_view;
            default:    sel_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_take) begin
            rd_data <= sel_word;
        end
    end
endmodule

// File: rtl/ofs_regfile.sv
module ofs_regfile
    import ofs_pkg::*;
#(
    parameter int DEPTH = 4096,
    parameter int OFS_W = ofs_width(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_sel,
    input  logic              wr_en,
    input  logic              rd_en_a,
    input  logic              rd_en_b,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic [OFS_W-1:0]  ae_offset,
    output logic [OFS_W-1:0]  af_offset
);
    access_t acc;
    slot_e   wr_slot;
    slot_e   rd_slot;
    logic    wr_take;
    logic    rd_take;

    ofs_arbiter u_arb (
        .cfg_sel (cfg_sel),
        .wr_en   (wr_en),
        .rd_en_a (rd_en_a),
        .rd_en_b (rd_en_b),
        .acc     (acc)
    );

    assign wr_take = acc.wr_take;
    assign rd_take = acc.rd_take;

    ofs_seq u_wr_seq (
        .clk  (clk),
        .rst  (rst),
        .step (wr_take),
        .slot (wr_slot)
    );

    ofs_seq u_rd_seq (
        .clk  (clk),
        .rst  (rst),
        .step (rd_take),
        .slot (rd_slot)
    );

    ofs_store #(.OFS_W(OFS_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_take (wr_take),
        .wr_slot (wr_slot),
        .wr_data (wr_data),
        .ae_ofs  (ae_offset),
        .af_ofs  (af_offset)
    );

    ofs_readback #(.OFS_W(OFS_W)) u_rdbk (
        .clk     (clk),
        .rst     (rst),
        .rd_take (rd_take),
        .rd_slot (rd_slot),
        .ae_ofs  (ae_offset),
        .af_ofs  (af_offset),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/ofs_regfile_chk.sv
module ofs_regfile_chk
    import ofs_pkg::*;
#(
    parameter int OFS_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_sel,
    input logic              wr_en,
    input logic              rd_en_a,
    input logic              rd_en_b,
    input logic              rd_take,
    input slot_e             wr_slot,
    input slot_e             rd_slot,
    input logic [WORD_W-1:0] rd_data,
    input logic [OFS_W-1:0]  ae_ofs,
    input logic [OFS_W-1:0]  af_ofs
);
    localparam int HI_W = OFS_W - WORD_W;

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ae_ofs == OFS_W'(RESET_OFS) && af_ofs == OFS_W'(RESET_OFS)
                        && rd_data == '0 && wr_slot == SLOT_AE_LO && rd_slot == SLOT_AE_LO));

    // R2
    wr_order_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_sel && wr_en) |=> (wr_slot == slot_next($past(wr_slot))));

    // R3
    wr_pause_chk: assert property (@(posedge clk) disable iff (rst)
        !(cfg_sel && wr_en) |=> $stable(wr_slot));

    // R4
    rd_order_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_sel && rd_en_a && rd_en_b && !wr_en) |=> (rd_slot == slot_next($past(rd_slot))));

    // R5
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(cfg_sel && rd_en_a && rd_en_b) |=> ($stable(rd_data) && $stable(rd_slot)));

    // R6
    conflict_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_sel && wr_en && rd_en_a && rd_en_b) |=> ($stable(rd_data) && $stable(rd_slot)));

    // R7
    hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_take && slot_is_hi(rd_slot)) |=> ((rd_data >> HI_W) == '0));

    // R8
    cfg_off_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_sel |=> ($stable(ae_ofs) && $stable(af_ofs) && $stable(wr_slot)));
endmodule

bind ofs_regfile ofs_regfile_chk #(.OFS_W(OFS_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cfg_sel (cfg_sel),
    .wr_en   (wr_en),
    .rd_en_a (rd_en_a),
    .rd_en_b (rd_en_b),
    .rd_take (rd_take),
    .wr_slot (wr_slot),
    .rd_slot (rd_slot),
    .rd_data (rd_data),
    .ae_ofs  (ae_offset),
    .af_ofs  (af_offset)
);

// File: tb/ofs_regfile_tb.sv
module ofs_regfile_tb;
    localparam int DEPTH = 4096;
    localparam int OW    = 11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_sel = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en_a = 1'b0;
    logic          rd_en_b = 1'b0;
    logic [8:0]    wr_data = '0;
    logic [8:0]    rd_data;
    logic [OW-1:0] ae_offset;
    logic [OW-1:0] af_offset;

    int n_chk  = 0;
    int n_fail = 0;

    logic [OW-1:0] m_ae;
    logic [OW-1:0] m_af;
    logic [8:0]    m_rd;
    logic [1:0]    m_wp;
    logic [1:0]    m_rp;

    always #5 clk = ~clk;

    ofs_regfile #(.DEPTH(DEPTH)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_sel   (cfg_sel),
        .wr_en     (wr_en),
        .rd_en_a   (rd_en_a),
        .rd_en_b   (rd_en_b),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .ae_offset (ae_offset),
        .af_offset (af_offset)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [8:0] view(input logic [1:0] p);
        case (p)
            2'd0:    return m_ae[8:0];
            2'd1:    return {7'b0, m_ae[10:9]};
            2'd2:    return m_af[8:0];
            default: return {7'b0, m_af[10:9]};
        endcase
    endfunction

    task automatic model_write(input logic [8:0] d);
        case (m_wp)
            2'd0:    m_ae[8:0]  = d;
            2'd1:    m_ae[10:9] = d[1:0];
            2'd2:    m_af[8:0]  = d;
            default: m_af[10:9] = d[1:0];
        endcase
        m_wp = m_wp + 2'd1;
    endtask

    task automatic compare(input string tag);
        check(tag, "ae_offset", int'(ae_offset), int'(m_ae));
        check(tag, "af_offset", int'(af_offset), int'(m_af));
        check(tag, "rd_data", int'(rd_data), int'(m_rd));
    endtask

    task automatic step(input logic c, input logic w, input logic a, input logic b,
                        input logic [8:0] d, input string tag);
        cfg_sel = c; wr_en = w; rd_en_a = a; rd_en_b = b; wr_data = d;
        @(posedge clk);
        if (c && w) begin
            model_write(d);
        end else if (c && a && b) begin
            m_rd = view(m_rp);
            m_rp = m_rp + 2'd1;
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1; cfg_sel = 0; wr_en = 0; rd_en_a = 0; rd_en_b = 0;
        repeat (3) @(posedge clk);
        m_ae = OW'(7); m_af = OW'(7); m_rd = '0; m_wp = '0; m_rp = '0;
        @(negedge clk);
        rst = 1'b0;
        compare("R1 reset");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        do_reset();
        check("R1", "ae reset literal", int'(ae_offset), 7);

        // R2 R7 R9: full load with ones in unused high-slot bits
        step(1, 1, 0, 0, 9'h0A5, "R2 ae lo");
        check("R9", "ae low visible", int'(ae_offset), 11'h0A5);
        step(1, 1, 0, 0, 9'h1FE, "R7 ae hi");
        check("R7", "ae hi bits", int'(ae_offset), {2'b10, 9'h0A5});
        step(1, 1, 0, 0, 9'h133, "R2 af lo");
        step(1, 1, 0, 0, 9'h1FD, "R7 af hi");
        check("R7", "af hi bits", int'(af_offset), {2'b01, 9'h133});

        // R4 R7: read-back in order
        step(1, 0, 1, 1, 9'h000, "R4 rd0");
        check("R4", "rd ae lo", int'(rd_data), 9'h0A5);
        step(1, 0, 1, 1, 9'h000, "R4 rd1");
        check("R7", "rd ae hi zero upper", int'(rd_data), 9'h002);
        step(1, 0, 1, 1, 9'h000, "R4 rd2");
        step(1, 0, 1, 1, 9'h000, "R4 rd3");
        check("R7", "rd af hi zero upper", int'(rd_data), 9'h001);

        // R2 wrap: fifth write lands on almost-empty low
        step(1, 1, 0, 0, 9'h011, "R2 wrap");
        check("R2", "wrap to ae lo", int'(ae_offset), {2'b10, 9'h011});

        // R3 pause then resume at ae hi
        repeat (3) step(0, 0, 0, 0, 9'h1FF, "R3 idle");
        step(1, 1, 0, 0, 9'h001, "R3 resume");
        check("R3", "resume ae hi", int'(ae_offset), {2'b01, 9'h011});

        // R8: strobes without cfg_sel
        step(0, 1, 0, 0, 9'h0FF, "R8 wr no sel");
        step(0, 0, 1, 1, 9'h000, "R8 rd no sel");
        check("R8", "af untouched", int'(af_offset), {2'b01, 9'h133});

        // R5: one read enable only
        step(1, 0, 1, 0, 9'h000, "R5 a only");
        step(1, 0, 0, 1, 9'h000, "R5 b only");
        check("R5", "rd hold", int'(rd_data), 9'h001);

        // R6: conflict, write taken, read ignored
        step(1, 1, 1, 1, 9'h0C3, "R6 conflict");
        check("R6", "write taken", int'(af_offset), {2'b01, 9'h0C3});
        check("R6", "read ignored", int'(rd_data), 9'h001);
        step(1, 0, 1, 1, 9'h000, "R6 rd after");
        check("R6", "rd pos kept", int'(rd_data), 9'h011);

        // random traffic, both positions independent (R2 R3 R4 R5 R6 R8)
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] r;
            r = 4'($urandom);
            step(r[0] | r[1], r[2], r[3] | r[1], r[3] | r[0],
                 9'($urandom), "R4 random");
        end

        // R1 second reset after traffic
        do_reset();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule